// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block models the host side of a floppy disk controller at byte level. The host uses three things. A control register write holds the controller in reset or lets it run. A status byte shows which handshake phase is active. A data port takes command and parameter bytes and returns result bytes. Each command goes through a parameter phase, an abstract execution step and a result phase. Sector data, DMA and drive mechanics stay outside the block. A read command's data phase ends when the `xfer_done` input pulses, and the geometry it reports back comes from the command's own parameters.

After the block leaves reset it owes the host a short series of interrupt-sense replies, one for each drive, in ascending drive order. Any other command issued before the series is used up cancels what is left of it. An interrupt request line tells the host when a reply is waiting.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After power-on reset, and after any control write with bit 2 clear, the block is held in reset. `stat` reads 0x00, `irq` is low, and data writes are ignored.
- R2: A control write with bit 2 set, made while the block is held in reset, releases it. `stat` becomes 0x80, `irq` rises, and a series of four post-reset replies is armed.
- R3: While post-reset replies remain, each interrupt-sense command (opcode low 5 bits 0x08) returns two bytes. The first is 0xC0 OR drive, and the second is cylinder 0x00. Drives are reported as 0, 1, 2 and 3 in that order.
- R4: `stat` reads 0x80 when idle, 0x90 while parameter bytes are accepted, and 0xD0 while result bytes are pending. It goes back to 0x80 after the last result byte is read.
- R5: The parameter count is set by opcode bits [4:0]: 0x07 (home) takes 1, 0x0F (seek) takes 2, 0x06 (read) takes 8, and 0x08 (sense) takes 0. Upper opcode bits are modifiers and are ignored.
- R6: Any command other than sense, issued while post-reset replies remain, discards those replies before it runs.
- R7: Home sets the cylinder to 0. Seek sets it to its second parameter. Both raise `irq`. The next sense returns 0x20 OR drive (first-parameter bits [1:0]) followed by the cylinder.
- R8: An unknown opcode returns the single byte 0x80. So does a sense command when nothing is pending.
- R9: After its eighth parameter, a read holds `stat` at 0x10 until `xfer_done` pulses. It then raises `irq` and returns seven bytes: first-parameter bits [2:0], 0x00, 0x00, then parameters 2, 3, 4 and 5.
- R10: `irq` falls when a sense command is written or when the first result byte is read.
- R11: Reads of the data port outside the result phase return 0x00 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, leaves the block held in reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value; bit 2 is the run bit |
| fifo_we | input | 1 | Data port write strobe (command or parameter byte) |
| fifo_wdata | input | 8 | Byte written to the data port |
| fifo_re | input | 1 | Data port read strobe; advances the result pointer |
| fifo_rdata | output | 8 | Current result byte, 0 outside the result phase |
| stat | output | 8 | Handshake status byte |
| xfer_done | input | 1 | Pulse that ends a read command's data phase |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the interaction between the post-reset series and other commands. The stimulus releases reset and consumes part of the series. It then issues a home command and follows it with sense commands. The first sense must report the seek-end status and must not report the next drive. The second must report nothing pending. A separate pass uses all four post-reset replies and then checks that a fifth sense falls back to the single 0x80 byte, which catches off-by-one drive numbering.

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq #(
  parameter int NPAR = 8,
  parameter int NRES = 7,
  parameter int NDRV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       fifo_we,
  input  logic [7:0] fifo_wdata,
  input  logic       fifo_re,
  output logic [7:0] fifo_rdata,
  output logic [7:0] stat,
  input  logic       xfer_done,
  output logic       irq
);
  localparam int PW = $clog2(NPAR + 1);
  localparam int RW = $clog2(NRES + 1);
  localparam int CW = $clog2(NDRV + 1);
  localparam logic [4:0] OP_HOME = 5'h07, OP_SEEK = 5'h0F, OP_READ = 5'h06, OP_SENSE = 5'h08;

  typedef enum logic [2:0] {S_RST, S_IDLE, S_PAR, S_EXEC, S_RES} ph_t;

  ph_t           ph;
  logic [4:0]    op;
  logic [7:0]    par [NPAR];
  logic [7:0]    res [NRES];
  logic [PW-1:0] pidx;
  logic [RW-1:0] ridx, rcnt;
  logic [CW-1:0] pend;
  logic [7:0]    sbyte, cyl;
  logic          seek_pend;

  function automatic logic [PW-1:0] need(input logic [4:0] o);
    case (o)
      OP_HOME: need = PW'(1);
      OP_SEEK: need = PW'(2);
      OP_READ: need = PW'(NPAR);
      default: need = '0;
    endcase
  endfunction

  wire cmd_wr = fifo_we && ph == S_IDLE;
  wire par_wr = fifo_we && ph == S_PAR;
  wire go = (cmd_wr && need(fifo_wdata[4:0]) == '0) || (par_wr && pidx == need(op) - PW'(1));
  wire [4:0] go_op = cmd_wr ? fifo_wdata[4:0] : op;
  wire [7:0] p0 = (par_wr && pidx == PW'(0)) ? fifo_wdata : par[0];
  wire [7:0] p1 = (par_wr && pidx == PW'(1)) ? fifo_wdata : par[1];
  wire [CW-1:0] drv_next = CW'(NDRV) - pend;

  always_comb begin
    case (ph)
      S_IDLE:  stat = 8'h80;
      S_PAR:   stat = 8'h90;
      S_EXEC:  stat = 8'h10;
      S_RES:   stat = 8'hD0;
      default: stat = 8'h00;
    endcase
  end
  assign fifo_rdata = (ph == S_RES) ? res[ridx] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_RST; op <= '0; pidx <= '0; ridx <= '0; rcnt <= '0;
      pend <= '0; sbyte <= '0; cyl <= '0; seek_pend <= 1'b0; irq <= 1'b0;
    end else if (ctl_we) begin
      if (!ctl_wdata[2]) begin
        ph <= S_RST; irq <= 1'b0;
      end else if (ph == S_RST) begin
        ph <= S_IDLE; irq <= 1'b1; pend <= CW'(NDRV);
        cyl <= '0; sbyte <= '0; seek_pend <= 1'b0;
      end
    end else begin
      case (ph)
        S_IDLE: if (fifo_we) begin
          op <= fifo_wdata[4:0];
          pidx <= '0;
          if (fifo_wdata[4:0] != OP_SENSE && pend != '0) begin
            pend <= '0; sbyte <= '0;
          end
          if (need(fifo_wdata[4:0]) != '0) ph <= S_PAR;
        end
        S_PAR: if (fifo_we) begin
          par[pidx] <= fifo_wdata;
          pidx <= pidx + PW'(1);
        end
        S_EXEC: if (xfer_done) begin
          res[0] <= {5'b0, par[0][2:0]};
          res[1] <= 8'h00;
          res[2] <= 8'h00;
          for (int i = 3; i < NRES; i++) res[i] <= par[i - 2];
          rcnt <= RW'(NRES); ridx <= '0; irq <= 1'b1; ph <= S_RES;
        end
        S_RES: if (fifo_re) begin
          if (ridx == '0) irq <= 1'b0;
          ridx <= ridx + RW'(1);
          if (ridx == rcnt - RW'(1)) ph <= S_IDLE;
        end
        default: ;
      endcase
      if (go) begin
        case (go_op)
          OP_SENSE: begin
            irq <= 1'b0; ph <= S_RES; ridx <= '0;
            if (pend != '0) begin
              res[0] <= 8'hC0 | 8'(drv_next);
              res[1] <= 8'h00;
              rcnt <= RW'(2);
              pend <= pend - CW'(1);
            end else if (seek_pend) begin
              res[0] <= sbyte; res[1] <= cyl; rcnt <= RW'(2); seek_pend <= 1'b0;
            end else begin
              res[0] <= 8'h80; rcnt <= RW'(1);
            end
          end
          OP_HOME: begin
            cyl <= '0; sbyte <= {6'b001000, p0[1:0]}; seek_pend <= 1'b1; irq <= 1'b1; ph <= S_IDLE;
          end
          OP_SEEK: begin
            cyl <= p1; sbyte <= {6'b001000, p0[1:0]}; seek_pend <= 1'b1; irq <= 1'b1; ph <= S_IDLE;
          end
          OP_READ: ph <= S_EXEC;
          default: begin
            res[0] <= 8'h80; rcnt <= RW'(1); ridx <= '0; ph <= S_RES;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic       fifo_we,
  input logic [7:0] fifo_wdata,
  input logic       xfer_done,
  input logic [7:0] stat,
  input logic [7:0] fifo_rdata,
  input logic       irq
);
  AST_STAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    stat == 8'h00 || stat == 8'h80 || stat == 8'h90 || stat == 8'h10 || stat == 8'hD0); // R4
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stat != 8'hD0 |-> fifo_rdata == 8'h00); // R11
  AST_HOLD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !ctl_wdata[2] |=> stat == 8'h00 && !irq); // R1
  AST_RELEASE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[2] && stat == 8'h00 |=> irq && stat == 8'h80); // R2
  AST_SENSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && fifo_we && stat == 8'h80 && fifo_wdata[4:0] == 5'h08 |=> !irq); // R10
  AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && !xfer_done && stat == 8'h10 |=> stat == 8'h10); // R9
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk u_chk (.*);

// File: tb/fdc_cmd_seq_bench.sv
module fdc_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, fifo_we = 1'b0, fifo_re = 1'b0, xfer_done = 1'b0;
  logic [7:0] ctl_wdata = '0, fifo_wdata = '0;
  logic [7:0] fifo_rdata, stat;
  logic irq;
  int ntest = 0, nfail = 0;
  logic [7:0] expq[$];
  string tagq[$];

  fdc_cmd_seq u_fdc_cmd_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step; @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntest++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic ctl(input logic [7:0] v);
    step; ctl_we = 1'b1; ctl_wdata = v; step; ctl_we = 1'b0;
  endtask
  task automatic wr(input logic [7:0] v);
    step; fifo_we = 1'b1; fifo_wdata = v; step; fifo_we = 1'b0;
  endtask
  task automatic rd;
    step; fifo_re = 1'b1; step; fifo_re = 1'b0;
  endtask
  task automatic want(input logic [7:0] b, input string req);
    expq.push_back(b); tagq.push_back(req);
  endtask
  task automatic drain(input int n);
    for (int i = 0; i < n; i++) rd;
  endtask

  always @(negedge clk) begin
    if (rst_n && fifo_re && stat == 8'hD0) begin
      if (expq.size() == 0) begin
        ntest++; nfail++;
        $display("FAIL R4 unexpected result actual=%0h expected=none", fifo_rdata);
      end else begin
        automatic logic [7:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        chk(fifo_rdata == e, t, fifo_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    ntest++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (3) step;
    rst_n = 1'b1; step;
    chk(stat == 8'h00, "R1 stat in reset", stat, 8'h00);
    chk(irq == 1'b0, "R1 irq in reset", irq, 0);
    wr(8'h07);
    chk(stat == 8'h00, "R1 write ignored", stat, 8'h00);

    ctl(8'h1C);
    chk(stat == 8'h80 && irq, "R2 release", {irq, stat}, 9'h180);

    for (int d = 0; d < 4; d++) begin
      wr(8'h08);
      chk(stat == 8'hD0, "R4 result phase", stat, 8'hD0);
      chk(irq == 1'b0, "R10 sense clears irq", irq, 0);
      want(8'hC0 | 8'(d), "R3 drive status");
      want(8'h00, "R3 cylinder");
      drain(2);
      chk(stat == 8'h80, "R4 back to idle", stat, 8'h80);
    end
    wr(8'h08); want(8'h80, "R8 sense nothing pending"); drain(1);

    step; fifo_re = 1'b1; #2;
    chk(fifo_rdata == 8'h00, "R11 idle read", fifo_rdata, 0);
    step; fifo_re = 1'b0;
    chk(stat == 8'h80, "R11 no state change", stat, 8'h80);

    ctl(8'h18);
    chk(stat == 8'h00 && !irq, "R1 held again", stat, 0);
    ctl(8'h1C);
    wr(8'h08); want(8'hC0, "R3 drive 0 first"); want(8'h00, "R3 cyl"); drain(2);
    wr(8'h07);
    chk(stat == 8'h90, "R5 home wants param", stat, 8'h90);
    wr(8'h00);
    chk(stat == 8'h80 && irq, "R7 home done irq", {irq, stat}, 9'h180);
    wr(8'h08); want(8'h20, "R6 cancelled series, seek end"); want(8'h00, "R7 cyl 0"); drain(2);
    wr(8'h08); want(8'h80, "R6 no leftover replies"); drain(1);

    wr(8'h0F);
    wr(8'h01);
    chk(stat == 8'h90, "R5 seek second param", stat, 8'h90);
    wr(8'h25);
    chk(stat == 8'h80 && irq, "R7 seek done irq", {irq, stat}, 9'h180);
    wr(8'h08); want(8'h21, "R7 seek status"); want(8'h25, "R7 seek cyl"); drain(2);

    wr(8'hE6);
    wr(8'h05); wr(8'h11); wr(8'h01); wr(8'h03); wr(8'h02); wr(8'h08);
    wr(8'h2A);
    chk(stat == 8'h90, "R5 read still in params", stat, 8'h90);
    wr(8'hFF);
    chk(stat == 8'h10, "R9 exec wait", stat, 8'h10);
    step; step;
    chk(stat == 8'h10, "R9 exec holds", stat, 8'h10);
    step; xfer_done = 1'b1; step; xfer_done = 1'b0;
    chk(stat == 8'hD0 && irq, "R9 read done irq", {irq, stat}, 9'h1D0);
    want(8'h05, "R9 st0"); want(8'h00, "R9 st1"); want(8'h00, "R9 st2");
    want(8'h11, "R9 C"); want(8'h01, "R9 H"); want(8'h03, "R9 R"); want(8'h02, "R9 N");
    rd;
    chk(irq == 1'b0, "R10 first read clears irq", irq, 0);
    drain(6);
    chk(stat == 8'h80, "R4 idle after read", stat, 8'h80);

    wr(8'h1F);
    chk(stat == 8'hD0, "R8 invalid gives result", stat, 8'hD0);
    want(8'h80, "R8 invalid byte"); drain(1);
    chk(stat == 8'h80, "R8 single byte", stat, 8'h80);

    wr(8'h0F);
    ctl(8'h18);
    wr(8'h33);
    chk(stat == 8'h00, "R1 reset mid-command", stat, 0);
    ctl(8'h1C);
    chk(stat == 8'h80, "R2 clean restart", stat, 8'h80);

    chk(expq.size() == 0, "R4 all results seen", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule